// File: doc/BRIEF.md
# Multi-Mode Configuration Cache

This block holds the context words that steer a two-dimensional array of reconfigurable cells, by default 8 rows by 8 columns. Each cell has its own storage element, and each element keeps several layers of context words. A single load port writes one layer. The write can go to a whole row of elements, a whole column, every element at once, or one chosen element. Loading is cheap when many cells share a word, and each cell can still hold a word of its own.

A layer select input picks the active layer for the whole array. On every clock edge, each element registers the word stored in the active layer onto its own slice of a flat context output bus. Software or a sequencer can preload the inactive layers while the array runs from the active one. A change of the select then switches every cell to its new context on one clock edge.

Cell `c` sits at row `c / COLS`, column `c % COLS`. Its context word occupies bits `[c*WORD_W +: WORD_W]` of the output bus.

Top module: `ctx_cache_top`

## Requirements
- R1: While `rst_n` is low, every stored word in every layer and every context output is cleared to zero.
- R2: A load with `ld_mode` = 2'b00 (row broadcast) writes `ld_word` into the addressed layer of the `COLS` elements of row `ld_index`.
- R3: A load with `ld_mode` = 2'b01 (column broadcast) writes `ld_word` into the addressed layer of the `ROWS` elements of column `ld_index`.
- R4: A load with `ld_mode` = 2'b10 (global broadcast) writes `ld_word` into the addressed layer of all elements, whatever the value of `ld_index`.
- R5: A load with `ld_mode` = 2'b11 (individual) writes `ld_word` into the addressed layer of the single element numbered `ld_index` (row*COLS + column).
- R6: A row broadcast with `ld_index` >= ROWS, or a column broadcast with `ld_index` >= COLS, writes no element.
- R7: A load changes only the layer named by `ld_layer`. All other layers of the written elements keep their contents.
- R8: A change of `layer_sel` moves every cell's output to the word of the new layer on the next rising edge, and not before it. With no load and a steady select, all outputs hold.
- R9: A load into the layer that is currently selected appears on the outputs of the written cells after the same edge that stores it.
- R10: While `ld_valid` is low, the load fields have no effect on any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load command present this cycle |
| ld_mode | input | 2 | Load mode: 00 row, 01 column, 10 all, 11 individual |
| ld_index | input | $clog2(ROWS*COLS) | Row, column or element number, depending on mode |
| ld_layer | input | $clog2(LAYERS) | Layer written by the load |
| ld_word | input | WORD_W | Context word to store |
| layer_sel | input | $clog2(LAYERS) | Active layer for the whole array |
| ctx_out | output | ROWS*COLS*WORD_W | Registered context word of every cell, cell c at [c*WORD_W +: WORD_W] |

## Verification
The bound checker checks the write-enable mask against the load command on every cycle: exactly one element in individual mode, a full row for an in-range row, nothing for an out-of-range index, and nothing without `ld_valid`. It also checks that the outputs hold when the select is steady and nothing loads into the active layer, and that a word loaded into the active layer reaches the output after one edge. The retention of unaddressed layers, the exact cell sets of the column and global broadcasts, and the one-edge switching of the whole array are shown by the bench. It keeps its own model of every element and layer and sweeps the select to compare all of them.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

   // Load mode encoding, visible at the ld_mode port
   typedef enum logic [1:0] {
      MODE_ROW = 2'b00,
      MODE_COL = 2'b01,
      MODE_ALL = 2'b10,
      MODE_ONE = 2'b11
   } cfg_mode_e;

endpackage

// File: rtl/cfgc_decode.sv
// Turns one load command into a per-element write-enable mask.
module cfgc_decode #(
   parameter int ROWS  = 8,
   parameter int COLS  = 8,
   parameter int IDX_W = 6
) (
   input  logic                 ld_valid,
   input  logic [1:0]           ld_mode,
   input  logic [IDX_W-1:0]     ld_index,
   output logic [ROWS*COLS-1:0] wr_mask
);
   import cfgc_pkg::*;

   cfg_mode_e mode;
   assign mode = cfg_mode_e'(ld_mode);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int CELL = r * COLS + c;
         logic row_hit, col_hit, one_hit;
         assign row_hit = (mode == MODE_ROW) && (ld_index == IDX_W'(r));
         assign col_hit = (mode == MODE_COL) && (ld_index == IDX_W'(c));
         assign one_hit = (mode == MODE_ONE) && (ld_index == IDX_W'(CELL));
         assign wr_mask[CELL] = ld_valid &&
                                ((mode == MODE_ALL) || row_hit || col_hit || one_hit);
      end
   end

endmodule

// File: rtl/cfgc_element.sv
// One cache element: LAYERS context words and a registered output of the active one.
module cfgc_element #(
   parameter int WORD_W  = 32,
   parameter int LAYERS  = 4,
   parameter int LAYER_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [LAYER_W-1:0] wr_layer,
   input  logic [WORD_W-1:0]  wr_word,
   input  logic [LAYER_W-1:0] rd_layer,
   output logic [WORD_W-1:0]  ctx_q
);

   logic [WORD_W-1:0] store_q [LAYERS];
   logic [WORD_W-1:0] rd_word;
   logic              rd_ok;
   logic              fwd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < LAYERS; l++) store_q[l] <= '0;
      end else if (we) begin
         for (int l = 0; l < LAYERS; l++)
            if (wr_layer == LAYER_W'(l)) store_q[l] <= wr_word;
      end
   end

   // Full index range when the layer count is a power of two;
   // otherwise unused select codes read as zero.
   if ((1 << LAYER_W) == LAYERS) begin : g_pow2
      assign rd_ok   = 1'b1;
      assign rd_word = store_q[rd_layer];
   end else begin : g_part
      assign rd_ok   = (rd_layer < LAYER_W'(LAYERS));
      assign rd_word = rd_ok ? store_q[rd_layer] : '0;
   end

   // A write into the active layer is forwarded so it shows after the same edge
   assign fwd = we && rd_ok && (wr_layer == rd_layer);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctx_q <= '0;
      else if (fwd) ctx_q <= wr_word;
      else          ctx_q <= rd_word;
   end

endmodule

// File: rtl/ctx_cache_top.sv
module ctx_cache_top #(
   parameter int ROWS    = 8,
   parameter int COLS    = 8,
   parameter int WORD_W  = 32,
   parameter int LAYERS  = 4,
   localparam int CELLS   = ROWS * COLS,
   localparam int IDX_W   = $clog2(CELLS),
   localparam int LAYER_W = $clog2(LAYERS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_valid,
   input  logic [1:0]              ld_mode,
   input  logic [IDX_W-1:0]        ld_index,
   input  logic [LAYER_W-1:0]      ld_layer,
   input  logic [WORD_W-1:0]       ld_word,
   input  logic [LAYER_W-1:0]      layer_sel,
   output logic [CELLS*WORD_W-1:0] ctx_out
);

   initial begin : param_chk
      if (ROWS < 2 || COLS < 2)
         $fatal(1, "ctx_cache_top: ROWS and COLS must be at least 2");
      if (LAYERS < 2)
         $fatal(1, "ctx_cache_top: LAYERS must be at least 2");
      if (WORD_W < 1)
         $fatal(1, "ctx_cache_top: WORD_W must be positive");
   end

   logic [CELLS-1:0] wr_mask;

   cfgc_decode #(
      .ROWS (ROWS),
      .COLS (COLS),
      .IDX_W(IDX_W)
   ) u_dec (
      .ld_valid(ld_valid),
      .ld_mode (ld_mode),
      .ld_index(ld_index),
      .wr_mask (wr_mask)
   );

   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      cfgc_element #(
         .WORD_W (WORD_W),
         .LAYERS (LAYERS),
         .LAYER_W(LAYER_W)
      ) u_el (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (wr_mask[c]),
         .wr_layer(ld_layer),
         .wr_word (ld_word),
         .rd_layer(layer_sel),
         .ctx_q   (ctx_out[c*WORD_W +: WORD_W])
      );
   end

endmodule

// File: rtl/cfgc_chk.sv
module cfgc_chk #(
   parameter int ROWS    = 8,
   parameter int COLS    = 8,
   parameter int WORD_W  = 32,
   parameter int LAYERS  = 4,
   localparam int CELLS   = ROWS * COLS,
   localparam int IDX_W   = $clog2(CELLS),
   localparam int LAYER_W = $clog2(LAYERS)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ld_valid,
   input logic [1:0]              ld_mode,
   input logic [IDX_W-1:0]        ld_index,
   input logic [LAYER_W-1:0]      ld_layer,
   input logic [WORD_W-1:0]       ld_word,
   input logic [LAYER_W-1:0]      layer_sel,
   input logic [CELLS-1:0]        wr_mask,
   input logic [CELLS*WORD_W-1:0] ctx_out
);

   // R5
   individual_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_mode == 2'b11) |-> ($countones(wr_mask) == 1));

   // R2
   row_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_mode == 2'b00 && ld_index < IDX_W'(ROWS))
         |-> ($countones(wr_mask) == COLS));

   // R6
   index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ((ld_mode == 2'b00 && ld_index >= IDX_W'(ROWS)) ||
                    (ld_mode == 2'b01 && ld_index >= IDX_W'(COLS))))
         |-> (wr_mask == '0));

   // R10
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |-> (wr_mask == '0));

   // R8
   output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!ld_valid || ld_layer != layer_sel) && $stable(layer_sel))
         |=> $stable(ctx_out));

   // R9
   write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_mode == 2'b11 && ld_layer == layer_sel)
         |=> (ctx_out[int'($past(ld_index)) * WORD_W +: WORD_W] == $past(ld_word)));

   // R4
   global_broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_mode == 2'b10 && ld_layer == layer_sel)
         |=> (ctx_out[WORD_W-1:0] == $past(ld_word) &&
              ctx_out[CELLS*WORD_W-1 -: WORD_W] == $past(ld_word)));

endmodule

bind ctx_cache_top cfgc_chk #(
   .ROWS  (ROWS),
   .COLS  (COLS),
   .WORD_W(WORD_W),
   .LAYERS(LAYERS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_valid (ld_valid),
   .ld_mode  (ld_mode),
   .ld_index (ld_index),
   .ld_layer (ld_layer),
   .ld_word  (ld_word),
   .layer_sel(layer_sel),
   .wr_mask  (wr_mask),
   .ctx_out  (ctx_out)
);

// File: tb/sim_ctx_cache_top.sv
module sim_ctx_cache_top;

   localparam int CLK_PERIOD = 10;
   localparam int ROWS = 8, COLS = 8, WORD_W = 32, LAYERS = 4;
   localparam int CELLS = ROWS * COLS;
   localparam int IDX_W = 6, LAYER_W = 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b1;
   logic                    ld_valid = 1'b0;
   logic [1:0]              ld_mode = '0;
   logic [IDX_W-1:0]        ld_index = '0;
   logic [LAYER_W-1:0]      ld_layer = '0;
   logic [WORD_W-1:0]       ld_word = '0;
   logic [LAYER_W-1:0]      layer_sel = '0;
   logic [CELLS*WORD_W-1:0] ctx_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [WORD_W-1:0] model [CELLS][LAYERS];

   always #(CLK_PERIOD/2) clk = ~clk;

   ctx_cache_top #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .LAYERS(LAYERS)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_mode(ld_mode),
      .ld_index(ld_index), .ld_layer(ld_layer), .ld_word(ld_word),
      .layer_sel(layer_sel), .ctx_out(ctx_out)
   );

   // {mode[1:0], index[5:0], layer[1:0], word[31:0], select[1:0]}
   localparam int VN = 11;
   localparam logic [43:0] VEC [VN] = '{
      {2'b10, 6'd0,  2'd0, 32'hA000_0000, 2'd0},  // all, R4
      {2'b00, 6'd3,  2'd0, 32'h0000_0B03, 2'd0},  // row 3, R2
      {2'b01, 6'd5,  2'd0, 32'h0000_0C05, 2'd0},  // column 5, R3
      {2'b11, 6'd29, 2'd0, 32'h1111_1111, 2'd0},  // cell 29, R5
      {2'b11, 6'd63, 2'd1, 32'h6363_6363, 2'd1},  // last cell, R5
      {2'b00, 6'd7,  2'd2, 32'h0000_0B07, 2'd2},  // row 7, R2
      {2'b01, 6'd0,  2'd3, 32'h0000_0C00, 2'd3},  // column 0, R3
      {2'b10, 6'd17, 2'd1, 32'hB1B1_B1B1, 2'd0},  // all into inactive layer, R7
      {2'b00, 6'd9,  2'd0, 32'hDEAD_0009, 2'd0},  // row out of range, R6
      {2'b01, 6'd63, 2'd2, 32'hDEAD_003F, 2'd2},  // column out of range, R6
      {2'b11, 6'd0,  2'd3, 32'h0000_3C3C, 2'd3}   // cell 0, R5
   };

   function automatic string tag_of(logic [1:0] m, logic [5:0] idx);
      if (m == 2'b00) return (idx >= ROWS) ? "R6" : "R2";
      if (m == 2'b01) return (idx >= COLS) ? "R6" : "R3";
      if (m == 2'b10) return "R4";
      return "R5";
   endfunction

   task automatic model_apply(logic [1:0] m, logic [5:0] idx, logic [1:0] lyr,
                              logic [31:0] w);
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) begin
            bit hit;
            hit = (m == 2'b10) || (m == 2'b00 && idx == r) ||
                  (m == 2'b01 && idx == c) || (m == 2'b11 && idx == r*COLS + c);
            if (hit) model[r*COLS + c][lyr] = w;
         end
   endtask

   task automatic model_clear();
      for (int c = 0; c < CELLS; c++)
         for (int l = 0; l < LAYERS; l++) model[c][l] = '0;
   endtask

   task automatic check_all(string tag);
      bit bad = 1'b0;
      n_chk++;
      for (int c = 0; c < CELLS; c++) begin
         if (!bad && ctx_out[c*WORD_W +: WORD_W] !== model[c][layer_sel]) begin
            bad = 1'b1;
            $display("FAIL %s cell %0d layer %0d: actual %h expected %h", tag, c,
                     layer_sel, ctx_out[c*WORD_W +: WORD_W], model[c][layer_sel]);
         end
      end
      if (bad) n_fail++;
   endtask

   task automatic check_cell(string tag, int c, logic [31:0] exp);
      n_chk++;
      if (ctx_out[c*WORD_W +: WORD_W] !== exp) begin
         n_fail++;
         $display("FAIL %s cell %0d: actual %h expected %h", tag, c,
                  ctx_out[c*WORD_W +: WORD_W], exp);
      end
   endtask

   task automatic load(logic [1:0] m, logic [5:0] idx, logic [1:0] lyr, logic [31:0] w);
      @(negedge clk);
      ld_mode = m; ld_index = idx; ld_layer = lyr; ld_word = w; ld_valid = 1'b1;
      @(negedge clk);
      ld_valid = 1'b0;
      model_apply(m, idx, lyr, w);
   endtask

   task automatic sweep_layers(string tag);
      for (int l = 0; l < LAYERS; l++) begin
         @(negedge clk);
         layer_sel = LAYER_W'(l);
         @(negedge clk);
         check_all(tag);
      end
   endtask

   initial begin
      model_clear();
      // R1: reset state on every layer
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      sweep_layers("R1");

      // Table of loads, each followed by a full-array compare
      for (int i = 0; i < VN; i++) begin
         logic [43:0] v;
         v = VEC[i];
         @(negedge clk);
         layer_sel = v[1:0];
         load(v[43:42], v[41:36], v[35:34], v[33:2]);
         check_all(tag_of(v[43:42], v[41:36]));
      end

      // R7: every layer still holds what the model says
      sweep_layers("R7");

      // R8: select change takes effect on the next edge only
      @(negedge clk);
      layer_sel = 2'd0;
      @(negedge clk);
      layer_sel = 2'd1;
      #1;
      check_cell("R8", 0, model[0][0]);
      @(negedge clk);
      check_all("R8");
      @(negedge clk);
      check_all("R8");

      // R9: write into the selected layer visible after one edge
      load(2'b11, 6'd42, 2'd1, 32'h0042_4242);
      check_cell("R9", 42, 32'h0042_4242);
      load(2'b00, 6'd0, 2'd1, 32'h0F0F_0F0F);
      check_all("R9");

      // R10: load fields without ld_valid
      @(negedge clk);
      ld_mode = 2'b10; ld_layer = 2'd1; ld_word = 32'hBAD0_BAD0; ld_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_all("R10");
      sweep_layers("R10");

      // R1: reset in mid-run clears all layers
      @(negedge clk);
      rst_n = 1'b0;
      model_clear();
      @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      sweep_layers("R1");

      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule